// File: doc/BRIEF.md
# Exception Cause and Return-Address Capture Unit

This block is the trap-control slice of the system coprocessor of a small 32-bit core. Five request sources feed it: an external interrupt line, a system-call decode, a breakpoint or divide-by-zero event, an undefined-instruction decode, and a signed-overflow condition. The unit detects the overflow condition itself from the operands, the result and the kind of the arithmetic operation. In any cycle where at least one source is active, the unit raises a redirect toward the fetch stage in that same cycle and presents a single fixed handler address. At the next clock edge it records the code of the winning source and the faulting instruction's PC.

The recorded code and PC sit outside the general register file. A move-from-coprocessor read port returns them when given a register identifier. Software returns from the handler by jumping to the saved PC. That jump happens outside this unit.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, both the cause register (identifier 13) and the saved-PC register (identifier 14) read as zero.
- R2: A taken exception writes a zero-extended code into the cause register at the clock edge that ends the request cycle. The codes are: undefined instruction 0x28, signed overflow 0x30, system call 0x20, breakpoint or divide-by-zero 0x24, interrupt 0x00.
- R3: For a signed add (alu_valid_i=1, alu_signed_i=1, alu_sub_i=0), overflow is raised exactly when the true two's-complement sum of alu_a_i and alu_b_i does not fit in 32 bits. Here alu_res_i carries the wrapped 32-bit sum.
- R4: For a signed subtract (alu_sub_i=1), overflow is raised exactly when the true difference alu_a_i minus alu_b_i does not fit in 32 bits. Here alu_res_i carries the wrapped difference.
- R5: An unsigned add or subtract (alu_signed_i=0), or any cycle with alu_valid_i=0, never raises overflow, whatever the operands.
- R6: When several requests arrive in one cycle, only one code is written. The order of precedence, highest first, is: undefined instruction, overflow, system call, breakpoint, interrupt.
- R7: redirect_o is high in exactly those cycles in which at least one request is active. handler_pc_o always equals 0x80000180.
- R8: A taken exception stores the pc_i value of the request cycle into the saved-PC register.
- R9: In a cycle with no request, the cause and saved-PC registers keep their values.
- R10: The read port is combinational. rd_sel_i=13 returns the cause register, rd_sel_i=14 returns the saved PC, and every other identifier returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 1 | External interrupt request |
| syscall_i | input | 1 | System-call decoded |
| brk_i | input | 1 | Breakpoint or divide-by-zero event |
| undef_i | input | 1 | Undefined instruction decoded |
| alu_valid_i | input | 1 | An add or subtract is executing |
| alu_signed_i | input | 1 | The operation is the trapping (signed) variant |
| alu_sub_i | input | 1 | 1 = subtract, 0 = add |
| alu_a_i | input | 32 | First operand |
| alu_b_i | input | 32 | Second operand |
| alu_res_i | input | 32 | Wrapped 32-bit result |
| pc_i | input | 32 | PC of the instruction raising the request |
| rd_sel_i | input | 5 | Coprocessor register identifier to read |
| rd_data_o | output | 32 | Read data |
| redirect_o | output | 1 | Fetch must jump to the handler |
| handler_pc_o | output | 32 | Handler entry address |

## Verification
A bad priority encoder or a bad overflow detector shows up in two places. It shows at once on redirect_o, in the request cycle itself. It also shows one edge later as a wrong code on the read port. A cause or saved-PC register that misses a write, or updates without a request, gives a wrong value at the next read through identifiers 13 and 14. The sweeps therefore read both registers after every request combination and after an idle cycle. Overflow detection is compared against exact wide arithmetic over operand pairs that straddle both signed limits.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int CODE_W  = 8;
   localparam int NUM_SRC = 5;

   // Source index: a higher index wins over a lower one
   localparam int SRC_IRQ   = 0;
   localparam int SRC_BRK   = 1;
   localparam int SRC_SYS   = 2;
   localparam int SRC_OVF   = 3;
   localparam int SRC_UNDEF = 4;

   localparam logic [CODE_W-1:0] CODE_IRQ   = 8'h00;
   localparam logic [CODE_W-1:0] CODE_SYS   = 8'h20;
   localparam logic [CODE_W-1:0] CODE_BRK   = 8'h24;
   localparam logic [CODE_W-1:0] CODE_UNDEF = 8'h28;
   localparam logic [CODE_W-1:0] CODE_OVF   = 8'h30;

   function automatic logic [CODE_W-1:0] code_of(input int idx);
      case (idx)
         SRC_BRK:   return CODE_BRK;
         SRC_SYS:   return CODE_SYS;
         SRC_OVF:   return CODE_OVF;
         SRC_UNDEF: return CODE_UNDEF;
         default:   return CODE_IRQ;
      endcase
   endfunction
endpackage

// File: rtl/exc_ovf_detect.sv
module exc_ovf_detect #(
   parameter int W           = 32,
   parameter bit TRAP_SIGNED = 1'b1
) (
   input  logic         valid_i,
   input  logic         signed_i,
   input  logic         sub_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] res_i,
   output logic         ovf_o
);
   localparam int MSB = W - 1;

   initial begin
      if (W < 2) $error("exc_ovf_detect: W must be at least 2");
   end

   generate
      if (TRAP_SIGNED) begin : g_trap
         logic same_sign, res_flip;
         always_comb begin
            // add: operands agree; sub: operands disagree
            same_sign = (a_i[MSB] == b_i[MSB]);
            res_flip  = (res_i[MSB] != a_i[MSB]);
            ovf_o     = valid_i & signed_i & res_flip & (sub_i ? ~same_sign : same_sign);
         end
      end else begin : g_notrap
         assign ovf_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc
   import exc_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic [N-1:0]      req_i,
   output logic              take_o,
   output logic [CODE_W-1:0] code_o
);
   initial begin
      if (N != NUM_SRC) $error("exc_prio_enc: N must equal NUM_SRC");
   end

   always_comb begin
      take_o = |req_i;
      code_o = CODE_IRQ;
      // ascending scan so the highest index present is left in code_o
      for (int i = 0; i < N; i++) begin
         if (req_i[i]) code_o = code_of(i);
      end
   end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
   import exc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [W-1:0]      pc_i,
   output logic [W-1:0]      cause_q,
   output logic [W-1:0]      epc_q
);
   initial begin
      if (W < CODE_W) $error("exc_state_regs: W narrower than cause code");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         epc_q   <= '0;
      end else if (take_i) begin
         cause_q <= {{(W-CODE_W){1'b0}}, code_i};
         epc_q   <= pc_i;
      end
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> ($stable(cause_q) && $stable(epc_q)));
   p_epc_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (epc_q == $past(pc_i)));
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
   import exc_pkg::*;
#(
   parameter int          XLEN        = 32,
   parameter int          SEL_W       = 5,
   parameter int          CAUSE_SEL   = 13,
   parameter int          EPC_SEL     = 14,
   parameter logic [31:0] HANDLER_PC  = 32'h8000_0180,
   parameter bit          TRAP_SIGNED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_i,
   input  logic             syscall_i,
   input  logic             brk_i,
   input  logic             undef_i,
   input  logic             alu_valid_i,
   input  logic             alu_signed_i,
   input  logic             alu_sub_i,
   input  logic [XLEN-1:0]  alu_a_i,
   input  logic [XLEN-1:0]  alu_b_i,
   input  logic [XLEN-1:0]  alu_res_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [SEL_W-1:0] rd_sel_i,
   output logic [XLEN-1:0]  rd_data_o,
   output logic             redirect_o,
   output logic [XLEN-1:0]  handler_pc_o
);
   localparam int SEL_MAX = (1 << SEL_W) - 1;

   initial begin
      if (XLEN != 32) $error("exc_ctrl_unit: XLEN must be 32");
      if (CAUSE_SEL == EPC_SEL) $error("exc_ctrl_unit: selectors collide");
      if (CAUSE_SEL > SEL_MAX || EPC_SEL > SEL_MAX) $error("exc_ctrl_unit: selector too wide");
   end

   logic               ovf;
   logic [NUM_SRC-1:0] req;
   logic               take;
   logic [CODE_W-1:0]  code;
   logic [XLEN-1:0]    cause_q, epc_q;

   exc_ovf_detect #(.W(XLEN), .TRAP_SIGNED(TRAP_SIGNED)) u_ovf (
      .valid_i (alu_valid_i),
      .signed_i(alu_signed_i),
      .sub_i   (alu_sub_i),
      .a_i     (alu_a_i),
      .b_i     (alu_b_i),
      .res_i   (alu_res_i),
      .ovf_o   (ovf)
   );

   always_comb begin
      req            = '0;
      req[SRC_IRQ]   = irq_i;
      req[SRC_BRK]   = brk_i;
      req[SRC_SYS]   = syscall_i;
      req[SRC_OVF]   = ovf;
      req[SRC_UNDEF] = undef_i;
   end

   exc_prio_enc #(.N(NUM_SRC)) u_prio (
      .req_i (req),
      .take_o(take),
      .code_o(code)
   );

   exc_state_regs #(.W(XLEN)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .code_i (code),
      .pc_i   (pc_i),
      .cause_q(cause_q),
      .epc_q  (epc_q)
   );

   assign redirect_o   = take;
   assign handler_pc_o = HANDLER_PC;

   always_comb begin
      if (rd_sel_i == SEL_W'(CAUSE_SEL))    rd_data_o = cause_q;
      else if (rd_sel_i == SEL_W'(EPC_SEL)) rd_data_o = epc_q;
      else                                   rd_data_o = '0;
   end

   p_undef_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      undef_i |=> (cause_q == XLEN'(CODE_UNDEF)));
   p_any_redirects_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i || syscall_i || brk_i || undef_i) |-> redirect_o);
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_i && !syscall_i && !brk_i && !undef_i && !alu_signed_i) |-> !redirect_o);
   p_cause_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> (cause_q[XLEN-1:CODE_W] == '0));
endmodule

// File: tb/tb_exc_ctrl_unit.sv
`timescale 1ns/1ps
module tb_exc_ctrl_unit;
   localparam real CYC = 20.0;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        irq_i = 0, syscall_i = 0, brk_i = 0, undef_i = 0;
   logic        alu_valid_i = 0, alu_signed_i = 0, alu_sub_i = 0;
   logic [31:0] alu_a_i = 0, alu_b_i = 0, alu_res_i = 0, pc_i = 0;
   logic [4:0]  rd_sel_i = 0;
   logic [31:0] rd_data_o, handler_pc_o;
   logic        redirect_o;

   int tests = 0, fails = 0;

   exc_ctrl_unit dut (.*);

   always #(CYC/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] sel, output logic [31:0] v);
      rd_sel_i = sel; #1; v = rd_data_o;
   endtask

   task automatic idle_inputs();
      irq_i = 0; syscall_i = 0; brk_i = 0; undef_i = 0;
      alu_valid_i = 0; alu_signed_i = 0; alu_sub_i = 0;
   endtask

   logic [31:0] ops [8];
   logic [31:0] v, last_cause, last_epc;

   initial begin
      #(CYC*200000);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      ops[0] = 32'h0000_0000; ops[1] = 32'h0000_0001; ops[2] = 32'hFFFF_FFFF;
      ops[3] = 32'h7FFF_FFFF; ops[4] = 32'h8000_0000; ops[5] = 32'h4000_0000;
      ops[6] = 32'hC000_0000; ops[7] = 32'h1234_5678;

      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset values, R10 read port
      rd(5'd13, v); chk("R1 cause after reset", v, 0);
      rd(5'd14, v); chk("R1 epc after reset", v, 0);
      chk("R7 handler address", handler_pc_o, 32'h8000_0180);
      chk("R7 no redirect when idle", {31'd0, redirect_o}, 0);

      last_cause = 0; last_epc = 0;
      // sweep every request combination: bit4 undef,3 ovf,2 sys,1 brk,0 irq
      for (int m = 0; m < 32; m++) begin
         logic [31:0] ecode;
         logic [31:0] epc;
         @(negedge clk);
         epc = 32'h0000_1000 + 32'(m) * 4;
         pc_i = epc;
         irq_i = m[0]; brk_i = m[1]; syscall_i = m[2]; undef_i = m[4];
         alu_valid_i = 1; alu_signed_i = m[3]; alu_sub_i = 0;
         alu_a_i = 32'h7FFF_FFFF; alu_b_i = 1; alu_res_i = 32'h8000_0000;
         #1;
         chk("R7 redirect per request set", {31'd0, redirect_o}, {31'd0, (m != 0)});
         if (m[4])      ecode = 32'h28;
         else if (m[3]) ecode = 32'h30;
         else if (m[2]) ecode = 32'h20;
         else if (m[1]) ecode = 32'h24;
         else           ecode = 32'h00;
         @(negedge clk);
         idle_inputs(); pc_i = 32'hDEAD_BEEF;
         if (m != 0) begin last_cause = ecode; last_epc = epc; end
         rd(5'd13, v); chk((m == 0) ? "R9 cause held" : "R2 R6 cause code", v, last_cause);
         rd(5'd14, v); chk((m == 0) ? "R9 epc held" : "R8 epc capture", v, last_epc);
      end

      // R9: an idle edge with a changing pc leaves state alone
      @(negedge clk); pc_i = 32'h5555_0000;
      @(negedge clk);
      rd(5'd13, v); chk("R9 cause hold idle", v, last_cause);
      rd(5'd14, v); chk("R9 epc hold idle", v, last_epc);

      // R10 other identifiers read zero while registers are nonzero
      for (int s = 0; s < 32; s++) begin
         if (s != 13 && s != 14) begin
            rd(5'(s), v); chk("R10 unused identifier reads zero", v, 0);
         end
      end

      // R3 R4 R5 overflow sweep against wide arithmetic
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            for (int k = 0; k < 4; k++) begin
               longint sa, sb, tr;
               logic exp_ovf;
               @(negedge clk);
               idle_inputs();
               sa = longint'($signed(ops[i])); sb = longint'($signed(ops[j]));
               alu_sub_i = k[0]; alu_signed_i = k[1]; alu_valid_i = 1;
               alu_a_i = ops[i]; alu_b_i = ops[j];
               tr = k[0] ? (sa - sb) : (sa + sb);
               alu_res_i = tr[31:0];
               exp_ovf = k[1] && (tr > 64'sd2147483647 || tr < -64'sd2147483648);
               pc_i = 32'h2000_0000 + 32'(i * 64 + j * 4 + k);
               #1;
               if (!k[1])     chk("R5 unsigned never overflows", {31'd0, redirect_o}, 0);
               else if (k[0]) chk("R4 signed sub overflow", {31'd0, redirect_o}, {31'd0, exp_ovf});
               else           chk("R3 signed add overflow", {31'd0, redirect_o}, {31'd0, exp_ovf});
               if (exp_ovf) begin last_cause = 32'h30; last_epc = pc_i; end
            end
         end
      end
      @(negedge clk); idle_inputs();
      rd(5'd13, v); chk("R2 overflow code after sweep", v, last_cause);
      rd(5'd14, v); chk("R8 epc after sweep", v, last_epc);

      // R5: valid low with overflowing operands
      @(negedge clk);
      alu_valid_i = 0; alu_signed_i = 1; alu_a_i = 32'h7FFF_FFFF; alu_b_i = 1;
      alu_res_i = 32'h8000_0000; #1;
      chk("R5 no overflow when not valid", {31'd0, redirect_o}, 0);
      @(negedge clk); idle_inputs();

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule